// File: doc/BRIEF.md
# External Interrupt Request Controller

This block is the front end for one active-low external interrupt pin. A single 8-bit control register, mapped at a fixed offset on a simple register bus, holds three settings: whether the pin raises a request while it is held low or only on a falling edge, whether the pin is connected to the interrupt logic at all, and whether leaving stop mode waits for a fixed oscillator settling time. The other bits of the register read as zero.

Two of these settings are protected according to the operating mode. In normal mode the edge selection and the stop-delay enable each accept one write after reset. In special mode the stop-delay enable may be written freely. The edge selection there ignores its first write and accepts every write after that. The pin is resynchronized inside the block. A falling edge is held until the processor acknowledges it. A stop-exit request returns a wake-done pulse, either at once or after the settling count.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset the register reads 0x60: bit 7 (edge select) = 0, bit 6 (pin enable) = 1 and bit 5 (stop-delay enable) = 1. Bits 4..0 always read 0, whatever is written to them. After reset irqReq and wakeDone are 0.
- R2: In level mode (bit 7 = 0) with bit 6 = 1, irqReq follows the inverted pin two clock edges after the pin changes.
- R3: In edge mode (bit 7 = 1) with bit 6 = 1, a high-to-low pin transition sets a pending request, and irqReq rises three clock edges after the pin falls. It then stays high after the pin returns high.
- R4: A one-cycle pulse on irqAck clears the pending edge request on the next clock edge.
- R5: Bit 6 can be written at any time in both modes. While it is 0 the pin raises no request in either mode.
- R6: A write that changes bit 7, or that clears bit 6, drops any pending edge request. irqReq is 0 after that write edge.
- R7: In normal mode (specialMode = 0) bit 7 takes its value from the first register write after reset. Later writes leave it unchanged.
- R8: In special mode (specialMode = 1) the first register write after reset leaves bit 7 unchanged. Every later write updates it.
- R9: Bit 5 takes only the first write after reset in normal mode. It takes every write in special mode.
- R10: With bit 5 = 1, a one-cycle stopExitReq gives a single-cycle wakeDone in the cycle that follows 4096 clock edges after the request was sampled. Before then wakeDone is 0.
- R11: With bit 5 = 0, wakeDone is 1 in the same cycle as stopExitReq, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| specialMode | input | 1 | 1 = special mode, 0 = normal mode |
| busAddr | input | ADDR_W | Register address |
| busWr | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data: the register when busAddr is the control offset, otherwise 0 |
| irqPinN | input | 1 | Active-low external interrupt pin (asynchronous) |
| irqAck | input | 1 | Clears a pending edge request |
| stopExitReq | input | 1 | Request to leave stop mode |
| wakeDone | output | 1 | Processing may resume |
| irqReq | output | 1 | Interrupt request to the core |

## Verification
The outputs become due at different times. A register write shows on the read data one edge after the write cycle. A level request follows the pin after two edges, and an edge request after three. An acknowledge or a clearing write takes effect after one edge. A delayed wake pulse appears exactly 4096 edges after the request, and an immediate wake appears in the request cycle itself. The driver records each expected value against the cycle number in which it is due. The monitor compares only in that cycle, at the falling clock edge. Checks made one cycle early and one cycle late pin each latency down exactly.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_EDGE = 7;
  localparam int BIT_PIN  = 6;
  localparam int BIT_DLY  = 5;
  localparam logic [REG_W-1:0] REG_RESET = 8'h60;

  // strobes and settings handed from control to datapath
  typedef struct packed {
    logic edgeMode;  // current edge-select setting
    logic pinOn;     // current pin-enable setting
    logic clrPend;   // configuration write drops pending edge
    logic ackPend;   // acknowledge from core
    logic startDly;  // load settling counter
    logic wakeNow;   // resume without delay
  } strobe_t;
endpackage

// File: rtl/extirq_ctl.sv
module extirq_ctl
  import extirq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 4'hE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              specialMode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [REG_W-1:0]  busWrData,
  input  logic              irqAck,
  input  logic              stopExitReq,
  output logic [REG_W-1:0]  regQ,
  output logic [REG_W-1:0]  busRdData,
  output strobe_t           stb
);
  logic edgeQ, pinQ, dlyQ;
  logic edgeSeenQ, dlySeenQ;
  logic wrHit, edgeOk, dlyOk;
  logic edgeD, pinD, dlyD;

  assign wrHit  = busWr && (busAddr == CTRL_OFFSET);
  // edge select: once in normal mode, skip-first in special mode
  assign edgeOk = specialMode ? edgeSeenQ : !edgeSeenQ;
  assign dlyOk  = specialMode || !dlySeenQ;

  always_comb begin
    edgeD = (wrHit && edgeOk) ? busWrData[BIT_EDGE] : edgeQ;
    pinD  = wrHit ? busWrData[BIT_PIN] : pinQ;
    dlyD  = (wrHit && dlyOk) ? busWrData[BIT_DLY] : dlyQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeQ     <= REG_RESET[BIT_EDGE];
      pinQ      <= REG_RESET[BIT_PIN];
      dlyQ      <= REG_RESET[BIT_DLY];
      edgeSeenQ <= 1'b0;
      dlySeenQ  <= 1'b0;
    end else begin
      edgeQ <= edgeD;
      pinQ  <= pinD;
      dlyQ  <= dlyD;
      if (wrHit) begin
        edgeSeenQ <= 1'b1;
        dlySeenQ  <= 1'b1;
      end
    end
  end

  always_comb begin
    regQ           = '0;
    regQ[BIT_EDGE] = edgeQ;
    regQ[BIT_PIN]  = pinQ;
    regQ[BIT_DLY]  = dlyQ;
    busRdData      = (busAddr == CTRL_OFFSET) ? regQ : '0;
  end

  always_comb begin
    stb.edgeMode = edgeQ;
    stb.pinOn    = pinQ;
    stb.clrPend  = wrHit && ((edgeD != edgeQ) || (pinQ && !pinD));
    stb.ackPend  = irqAck;
    stb.startDly = stopExitReq && dlyQ;
    stb.wakeNow  = stopExitReq && !dlyQ;
  end
endmodule

// File: rtl/extirq_dp.sv
module extirq_dp
  import extirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DLY_W       = 12
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    irqPinN,
  input  strobe_t stb,
  output logic    irqReq,
  output logic    wakeDone
);
  localparam logic [DLY_W-1:0] DLY_LOAD = {DLY_W{1'b1}};

  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ, pendQ, pinNow, fallSeen;
  logic busyQ;
  logic [DLY_W-1:0] cntQ;

  // pin resynchronizer, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
      prevQ <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], irqPinN};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign pinNow   = syncQ[SYNC_STAGES-1];
  assign fallSeen = prevQ && !pinNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pendQ <= 1'b0;
    else if (stb.clrPend)
      pendQ <= 1'b0;
    else if (fallSeen && stb.pinOn && stb.edgeMode)
      pendQ <= 1'b1;
    else if (stb.ackPend)
      pendQ <= 1'b0;
  end

  assign irqReq = stb.pinOn && (stb.edgeMode ? pendQ : !pinNow);

  // stop-exit settling counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (stb.startDly) begin
      busyQ <= 1'b1;
      cntQ  <= DLY_LOAD;
    end else if (busyQ) begin
      if (cntQ == '0) busyQ <= 1'b0;
      else            cntQ  <= cntQ - 1'b1;
    end
  end

  assign wakeDone = stb.wakeNow || (busyQ && (cntQ == '0));
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 4'hE,
  parameter int SYNC_STAGES = 2,
  parameter int DLY_W       = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              specialMode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              irqPinN,
  input  logic              irqAck,
  input  logic              stopExitReq,
  output logic              wakeDone,
  output logic              irqReq
);
  strobe_t stb;
  logic [REG_W-1:0] regQ;

  extirq_ctl #(.ADDR_W(ADDR_W), .CTRL_OFFSET(CTRL_OFFSET)) u_ctl (
    .clk(clk), .rstN(rstN), .specialMode(specialMode),
    .busAddr(busAddr), .busWr(busWr), .busWrData(busWrData),
    .irqAck(irqAck), .stopExitReq(stopExitReq),
    .regQ(regQ), .busRdData(busRdData), .stb(stb)
  );

  extirq_dp #(.SYNC_STAGES(SYNC_STAGES), .DLY_W(DLY_W)) u_dp (
    .clk(clk), .rstN(rstN), .irqPinN(irqPinN), .stb(stb),
    .irqReq(irqReq), .wakeDone(wakeDone)
  );
endmodule

// File: rtl/extirq_chk.sv
module extirq_chk #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 4'hE
) (
  input logic              clk,
  input logic              rstN,
  input logic              specialMode,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [7:0]        regQ,
  input logic [7:0]        busRdData,
  input logic              stopExitReq,
  input logic              wakeDone,
  input logic              irqReq
);
  logic anyWrQ, hit;
  assign hit = busWr && (busAddr == CTRL_OFFSET);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    anyWrQ <= 1'b0;
    else if (hit) anyWrQ <= 1'b1;
  end

  a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[4:0] == 5'd0);

  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !regQ[6] |-> !irqReq);

  a_r7_edge_locked: assert property (@(posedge clk) disable iff (!rstN)
    (!specialMode && hit && anyWrQ) |=> $stable(regQ[7]));

  a_r8_first_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (specialMode && hit && !anyWrQ) |=> $stable(regQ[7]));

  a_r9_delay_locked: assert property (@(posedge clk) disable iff (!rstN)
    (!specialMode && hit && anyWrQ) |=> $stable(regQ[5]));

  a_r10_wake_single: assert property (@(posedge clk) disable iff (!rstN)
    (wakeDone && !stopExitReq) |=> (!wakeDone || stopExitReq));

  a_r11_wake_immediate: assert property (@(posedge clk) disable iff (!rstN)
    (stopExitReq && !regQ[5]) |-> wakeDone);
endmodule

bind extirq_ctrl extirq_chk #(.ADDR_W(ADDR_W), .CTRL_OFFSET(CTRL_OFFSET)) u_chk (
  .clk(clk), .rstN(rstN), .specialMode(specialMode), .busAddr(busAddr),
  .busWr(busWr), .regQ(regQ), .busRdData(busRdData),
  .stopExitReq(stopExitReq), .wakeDone(wakeDone), .irqReq(irqReq)
);

// File: tb/sim_extirq_ctrl.sv
`timescale 1ns/1ps
module sim_extirq_ctrl;
  localparam int SIG_RD = 0, SIG_IRQ = 1, SIG_WAKE = 2;

  logic clk = 1'b0, rstN = 1'b0, specialMode = 1'b0;
  logic [3:0] busAddr = 4'hE;
  logic busWr = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic irqPinN = 1'b1, irqAck = 1'b0, stopExitReq = 1'b0;
  logic wakeDone, irqReq;

  int cyc = 0, total = 0, bad = 0;
  logic finished = 1'b0;

  typedef struct { int due; int sig; int val; int req; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  extirq_ctrl u0 (
    .clk(clk), .rstN(rstN), .specialMode(specialMode), .busAddr(busAddr),
    .busWr(busWr), .busWrData(busWrData), .busRdData(busRdData),
    .irqPinN(irqPinN), .irqAck(irqAck), .stopExitReq(stopExitReq),
    .wakeDone(wakeDone), .irqReq(irqReq)
  );

  // monitor: compares every item due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        int got;
        got = (sb[i].sig == SIG_RD) ? int'(busRdData) :
              (sb[i].sig == SIG_IRQ) ? int'(irqReq) : int'(wakeDone);
        total++;
        if (got != sb[i].val) begin
          bad++;
          $display("FAIL R%0d sig=%0d cycle=%0d actual=%0h expected=%0h",
                   sb[i].req, sb[i].sig, cyc, got, sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectAt(int off, int sig, int val, int req);
    exp_t e;
    e.due = cyc + off; e.sig = sig; e.val = val; e.req = req;
    sb.push_back(e);
  endtask

  task automatic doReset(logic special);
    rstN = 1'b0; specialMode = special; busWr = 1'b0; irqAck = 1'b0;
    stopExitReq = 1'b0; irqPinN = 1'b1;
    tick(3);
    rstN = 1'b1;
  endtask

  task automatic regWrite(logic [7:0] v);
    busWr = 1'b1; busWrData = v;
    tick(1);
    busWr = 1'b0;
  endtask

  initial begin
    // ---- normal mode ----
    doReset(1'b0);
    expectAt(0, SIG_RD, 8'h60, 1);   // R1
    expectAt(0, SIG_IRQ, 0, 1);
    expectAt(0, SIG_WAKE, 0, 1);
    tick(1);
    irqPinN = 1'b0;                  // R2 level
    expectAt(1, SIG_IRQ, 0, 2);
    expectAt(2, SIG_IRQ, 1, 2);
    tick(4);
    irqPinN = 1'b1;
    expectAt(1, SIG_IRQ, 1, 2);
    expectAt(2, SIG_IRQ, 0, 2);
    tick(4);
    regWrite(8'hC0); expectAt(0, SIG_RD, 8'hC0, 7); tick(1);
    regWrite(8'h00); expectAt(0, SIG_RD, 8'h80, 7); tick(1);  // R7, R5
    regWrite(8'hE0); expectAt(0, SIG_RD, 8'hC0, 9); tick(1);  // R9 locked
    irqPinN = 1'b0;                  // R3 edge
    expectAt(2, SIG_IRQ, 0, 3);
    expectAt(3, SIG_IRQ, 1, 3);
    tick(5);
    irqPinN = 1'b1;
    expectAt(3, SIG_IRQ, 1, 3);
    tick(5);
    irqAck = 1'b1; tick(1); irqAck = 1'b0;
    expectAt(0, SIG_IRQ, 0, 4);      // R4
    tick(2);
    irqPinN = 1'b0; tick(4);
    expectAt(0, SIG_IRQ, 1, 3);
    irqPinN = 1'b1; tick(3);
    regWrite(8'h80);                 // R6 clearing pin enable
    expectAt(0, SIG_IRQ, 0, 6);
    expectAt(0, SIG_RD, 8'h80, 5);
    tick(1);
    regWrite(8'hC0);
    expectAt(0, SIG_IRQ, 0, 6);
    tick(2);
    regWrite(8'h80); tick(1);        // R5 disabled pin
    irqPinN = 1'b0; tick(5);
    expectAt(0, SIG_IRQ, 0, 5);
    irqPinN = 1'b1; tick(4);
    regWrite(8'hC0);
    expectAt(0, SIG_IRQ, 0, 5);
    expectAt(1, SIG_IRQ, 0, 5);
    tick(3);
    stopExitReq = 1'b1;              // R11
    expectAt(0, SIG_WAKE, 1, 11);
    tick(1); stopExitReq = 1'b0;
    expectAt(0, SIG_WAKE, 0, 11);
    tick(2);

    // ---- normal mode, delay enabled ----
    doReset(1'b0);
    tick(1);
    stopExitReq = 1'b1;              // R10
    expectAt(0, SIG_WAKE, 0, 10);
    expectAt(4095, SIG_WAKE, 0, 10);
    expectAt(4096, SIG_WAKE, 1, 10);
    expectAt(4097, SIG_WAKE, 0, 10);
    tick(1); stopExitReq = 1'b0;
    tick(4100);
    regWrite(8'h20); expectAt(0, SIG_RD, 8'h20, 5); tick(1);
    irqPinN = 1'b0; tick(4);
    expectAt(0, SIG_IRQ, 0, 5);      // R5 level mode blocked
    irqPinN = 1'b1; tick(3);
    regWrite(8'hE0); expectAt(0, SIG_RD, 8'h60, 7); tick(2);  // R7, R9

    // ---- special mode ----
    doReset(1'b1);
    tick(1);
    regWrite(8'hC0); expectAt(0, SIG_RD, 8'h40, 8); tick(1);  // R8 first dropped
    regWrite(8'hFF); expectAt(0, SIG_RD, 8'hE0, 1); tick(1);  // R1 low bits
    regWrite(8'h40); expectAt(0, SIG_RD, 8'h40, 9); tick(1);  // R8, R9 free
    regWrite(8'hE0); expectAt(0, SIG_RD, 8'hE0, 8); tick(1);
    irqPinN = 1'b0; tick(4);
    expectAt(0, SIG_IRQ, 1, 3);
    irqPinN = 1'b1; tick(3);
    expectAt(0, SIG_IRQ, 1, 3);
    tick(1);
    regWrite(8'h60);                 // R6 edge select change
    expectAt(0, SIG_IRQ, 0, 6);
    expectAt(0, SIG_RD, 8'h60, 8);
    tick(3);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R0 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule